// File: doc/BRIEF.md
# Four-Region Packet Address Translator

This block turns the address carried by an incoming packet into a local bus address. The packet address space is split into four windows placed back to back. Each window has a programmable length and a programmable local offset. An address that falls inside a window is rebased to the start of that window and then moved to that window's offset. An address beyond all four windows maps to zero. The block also handles the outbound direction: it subtracts a programmable transmit base from the low 26 bits of a local bus address, which gives a packet address that starts at zero.

Software loads the window lengths, the window offsets and the transmit base through a simple write port. All of these values are word aligned. Each inbound lookup takes one clock cycle. The result is returned with a registered valid, a hit flag and the index of the window that matched.

Top module: `pkt_addr_xlate`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` in the register chosen by `cfg_sel_i` (0..3: lengths of windows 1..4; 4..7: offsets of windows 1..4; 8: transmit base). The new value first affects a lookup whose `pkt_valid_i` is sampled on the edge after the write edge. A lookup sampled on the same edge as the write uses the old value.
- R2: Bits 1:0 of every length, offset and transmit base write are discarded and taken as zero.
- R3: A packet address below length 1 translates to that address plus offset 1, with `hit_o`=1 and `region_o`=0.
- R4: Window n (n = 2..4) covers addresses from the sum of the lengths of windows 1..n-1 up to, but not including, the sum of the lengths of windows 1..n. An address in window n translates to the address minus the sum of the preceding lengths, plus offset n, with `region_o`=n-1.
- R5: An address at or beyond the sum of all four lengths gives `loc_addr_o`=0, `hit_o`=0 and `region_o`=0.
- R6: A window of length zero never matches and adds nothing to the running sums. The windows are tested in the order 1 to 4, and the first one that matches wins.
- R7: `loc_valid_o` is high exactly one cycle after each cycle in which `pkt_valid_i` is high. `loc_addr_o`, `hit_o` and `region_o` hold their values while no new lookup arrives.
- R8: One cycle after `tx_valid_i` is high, `tx_valid_o` is high and `tx_pkt_addr_o` equals `tx_bus_addr_i[25:0]` minus the transmit base, taken modulo 2^26. Bits 31:26 of `tx_bus_addr_i` have no effect.
- R9: After reset all registers are zero, every lookup misses, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 4 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| pkt_valid_i | input | 1 | Inbound packet address valid |
| pkt_addr_i | input | 26 | Inbound packet address |
| loc_valid_o | output | 1 | Translated address valid |
| loc_addr_o | output | 32 | Translated local address |
| hit_o | output | 1 | Address fell inside a window |
| region_o | output | 2 | Index of the matching window |
| tx_valid_i | input | 1 | Outbound bus address valid |
| tx_bus_addr_i | input | 32 | Outbound local bus address |
| tx_valid_o | output | 1 | Outbound packet address valid |
| tx_pkt_addr_o | output | 26 | Zero-based outbound packet address |

## Verification
Three window layouts are swept one address at a time, from zero to past the end of the last window:
- Unequal lengths with offsets spread across the 32-bit space. This separates the per-window rebasing from a plain offset add, and each window boundary from the address just below it.
- A layout with a zero-length second window. This tells a correct skip apart from a window that wrongly matches or shifts the running sums.
- A layout written with nonzero low bits. This catches any leak of bits 1:0.

A write issued on the same edge as a lookup tells "new value next cycle" apart from "new value at once". The outbound path is checked with addresses that have high bits set and with subtractions that wrap.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned ALIGN_LSB = 2;

  function automatic logic [31:0] word_align(input logic [31:0] v);
    return {v[31:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs #(
  parameter int unsigned AW   = 26,
  parameter int unsigned BW   = 32,
  parameter int unsigned NREG = 4,
  parameter int unsigned SELW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SELW-1:0]          sel_i,
  input  logic [BW-1:0]            wdata_i,
  output logic [NREG-1:0][AW-1:0]  size_o,
  output logic [NREG-1:0][BW-1:0]  off_o,
  output logic [AW-1:0]            txb_o
);
  import xlate_pkg::*;

  logic [BW-1:0] wdata_al;
  assign wdata_al = BW'(word_align(32'(wdata_i)));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        size_o[g] <= '0;
        off_o[g]  <= '0;
      end else if (we_i) begin
        if (sel_i == SELW'(g))        size_o[g] <= wdata_al[AW-1:0];
        if (sel_i == SELW'(NREG + g)) off_o[g]  <= wdata_al;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               txb_o <= '0;
    else if (we_i && sel_i == SELW'(2 * NREG)) txb_o <= wdata_al[AW-1:0];
  end
endmodule

// File: rtl/xlate_region_match.sv
module xlate_region_match #(
  parameter int unsigned AW   = 26,
  parameter int unsigned BW   = 32,
  parameter int unsigned NREG = 4,
  parameter int unsigned RW   = 2
) (
  input  logic [NREG-1:0][AW-1:0] size_i,
  input  logic [NREG-1:0][BW-1:0] off_i,
  input  logic [AW-1:0]           addr_i,
  output logic                    hit_o,
  output logic [RW-1:0]           idx_o,
  output logic [BW-1:0]           xaddr_o
);
  localparam int unsigned SW = AW + RW;

  logic [NREG:0][SW-1:0] base;
  logic [NREG-1:0]       match;
  logic [SW-1:0]         addr_ext;

  assign addr_ext = {{RW{1'b0}}, addr_i};
  assign base[0]  = '0;

  // running sums of the window lengths
  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign base[g+1] = base[g] + {{RW{1'b0}}, size_i[g]};
    assign match[g]  = (addr_ext >= base[g]) && (addr_ext < base[g+1]);
  end

  // lowest window wins
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    xaddr_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o   = 1'b1;
        idx_o   = RW'(i);
        xaddr_o = off_i[i] + {{(BW-AW){1'b0}}, addr_i - base[i][AW-1:0]};
      end
    end
  end
endmodule

// File: rtl/pkt_addr_xlate.sv
module pkt_addr_xlate #(
  parameter int unsigned AW   = 26,
  parameter int unsigned BW   = 32,
  parameter int unsigned NREG = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [$clog2(2*NREG+1)-1:0] cfg_sel_i,
  input  logic [BW-1:0]            cfg_wdata_i,
  input  logic                     pkt_valid_i,
  input  logic [AW-1:0]            pkt_addr_i,
  output logic                     loc_valid_o,
  output logic [BW-1:0]            loc_addr_o,
  output logic                     hit_o,
  output logic [$clog2(NREG)-1:0]  region_o,
  input  logic                     tx_valid_i,
  input  logic [BW-1:0]            tx_bus_addr_i,
  output logic                     tx_valid_o,
  output logic [AW-1:0]            tx_pkt_addr_o
);
  localparam int unsigned SELW = $clog2(2*NREG+1);
  localparam int unsigned RW   = $clog2(NREG);

  logic [NREG-1:0][AW-1:0] size_q;
  logic [NREG-1:0][BW-1:0] off_q;
  logic [AW-1:0]           txb_q;
  logic                    m_hit;
  logic [RW-1:0]           m_idx;
  logic [BW-1:0]           m_xaddr;
  logic                    unused_hi;

  assign unused_hi = ^tx_bus_addr_i[BW-1:AW];

  xlate_cfg_regs #(.AW(AW), .BW(BW), .NREG(NREG), .SELW(SELW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .size_o  (size_q),
    .off_o   (off_q),
    .txb_o   (txb_q)
  );

  xlate_region_match #(.AW(AW), .BW(BW), .NREG(NREG), .RW(RW)) u_match (
    .size_i  (size_q),
    .off_i   (off_q),
    .addr_i  (pkt_addr_i),
    .hit_o   (m_hit),
    .idx_o   (m_idx),
    .xaddr_o (m_xaddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_valid_o <= 1'b0;
      loc_addr_o  <= '0;
      hit_o       <= 1'b0;
      region_o    <= '0;
    end else begin
      loc_valid_o <= pkt_valid_i;
      if (pkt_valid_i) begin
        loc_addr_o <= m_xaddr;
        hit_o      <= m_hit;
        region_o   <= m_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o    <= 1'b0;
      tx_pkt_addr_o <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) tx_pkt_addr_o <= tx_bus_addr_i[AW-1:0] - txb_q;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> loc_valid_o);
  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !loc_valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> ($stable(loc_addr_o) && $stable(hit_o) && $stable(region_o)));
  a_r5_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_valid_o && !hit_o) |-> (loc_addr_o == '0 && region_o == '0));
  a_r8_tx_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_valid_o);
  a_r8_tx_rebase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> ((tx_pkt_addr_o + $past(txb_q)) == $past(tx_bus_addr_i[AW-1:0])));
  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_pkt_addr_o[1:0] != 2'b00) |-> $past(tx_bus_addr_i[1:0]) == tx_pkt_addr_o[1:0]);
endmodule

// File: tb/sim_pkt_addr_xlate.sv
module sim_pkt_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pkt_valid = 1'b0;
  logic [25:0] pkt_addr = '0;
  logic        loc_valid;
  logic [31:0] loc_addr;
  logic        hit;
  logic [1:0]  region;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_bus_addr = '0;
  logic        tx_valid_o;
  logic [25:0] tx_pkt_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] sz [4];
  logic [31:0] of [4];

  always #10 clk = ~clk;

  pkt_addr_xlate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .pkt_valid_i(pkt_valid), .pkt_addr_i(pkt_addr),
    .loc_valid_o(loc_valid), .loc_addr_o(loc_addr), .hit_o(hit), .region_o(region),
    .tx_valid_i(tx_valid), .tx_bus_addr_i(tx_bus_addr), .tx_valid_o(tx_valid_o),
    .tx_pkt_addr_o(tx_pkt_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 4)       sz[sel]     = d & 32'hFFFF_FFFC;
    else if (sel < 8)  of[sel - 4] = d & 32'hFFFF_FFFC;
  endtask

  // expected lookup: {hit, region, address}
  function automatic logic [34:0] model(input logic [31:0] a);
    logic [31:0] b = 0;
    for (int i = 0; i < 4; i++) begin
      if (a >= b && a < b + sz[i]) return {1'b1, 2'(i), of[i] + (a - b)};
      b = b + sz[i];
    end
    return '0;
  endfunction

  task automatic look(input string req, input logic [25:0] a);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_addr = a;
    @(negedge clk);
    pkt_valid = 1'b0;
    check({req, " valid"}, 64'(loc_valid), 64'd1);
    check(req, 64'({hit, region, loc_addr}), 64'(model(32'(a))));
  endtask

  task automatic sweep(input string req, input int top);
    for (int a = 0; a <= top; a += 4) look(req, 26'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sz[i] = 0; of[i] = 0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset outputs", 64'({loc_valid, hit, region, loc_addr, tx_valid_o, tx_pkt_addr}), 64'd0);
    rst_ni = 1'b1;
    look("R9 miss after reset", 26'h40);
    check("R9 addr zero", 64'({hit, loc_addr}), 64'd0);

    // layout A: R3 R4 R5
    wr(0, 32'h10); wr(1, 32'h20); wr(2, 32'h8); wr(3, 32'h40);
    wr(4, 32'h1000); wr(5, 32'h2000_0000); wr(6, 32'h8200_0000); wr(7, 32'hFFFF_FF00);
    look("R3 first word", 26'h0);
    look("R4 boundary win2", 26'h10);
    look("R4 boundary win4", 26'h38);
    look("R5 end", 26'h78);
    sweep("R3/R4/R5 sweep A", 32'h90);

    // R7 hold: idle cycles keep outputs
    begin
      logic [34:0] keep = {hit, region, loc_addr};
      repeat (3) @(negedge clk);
      check("R7 hold", 64'({hit, region, loc_addr}), 64'(keep));
      check("R7 no valid", 64'(loc_valid), 64'd0);
    end

    // layout B: zero-length window 2 (R6)
    wr(1, 32'h0);
    look("R6 skip", 26'h10);
    check("R6 region index", 64'(region), 64'd2);
    sweep("R6 sweep B", 32'h80);

    // layout C: low bits dropped (R2)
    wr(0, 32'h13); wr(4, 32'h1003); wr(1, 32'h7);
    look("R2 size low bits", 26'h10);
    check("R2 window2 len 4", 64'(region), 64'd1);
    sweep("R2 sweep C", 32'h80);

    // R1: write on the same edge as a lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd4; cfg_wdata = 32'h5000;
    pkt_valid = 1'b1; pkt_addr = 26'h4;
    @(negedge clk);
    cfg_we = 1'b0; pkt_valid = 1'b0;
    check("R1 old value in flight", 64'(loc_addr), 64'h1004);
    of[0] = 32'h5000;
    look("R1 new value next", 26'h4);
    check("R1 new offset", 64'(loc_addr), 64'h5004);

    // R8 outbound
    wr(8, 32'h103);
    @(negedge clk); tx_valid = 1'b1; tx_bus_addr = 32'hFC00_0154;
    @(negedge clk); tx_valid = 1'b0;
    check("R8 valid", 64'(tx_valid_o), 64'd1);
    check("R8 rebase high bits ignored", 64'(tx_pkt_addr), 64'h54);
    @(negedge clk); tx_valid = 1'b1; tx_bus_addr = 32'h0000_0010;
    @(negedge clk); tx_valid = 1'b0;
    check("R8 wrap", 64'(tx_pkt_addr), 64'h3FF_FF10);
    @(negedge clk);
    check("R8 valid drops", 64'(tx_valid_o), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule